// File: doc/BRIEF.md
# Power-on and Push-Button Reset Supervisor

This block generates the active-low system reset for a chip. Reset is held low while the power-on reset is applied, while the power-good indication is low, and while a push-button manual reset is held. Once every hold source clears, a counter runs for a fixed number of clock cycles. The reset output is released at the end of that count.

Any hold source pulls the output low at once, with no clock edge involved. Release happens only on a clock edge. A manual reset keeps the output low for the whole button press, and the time-out count starts only after the button is let go. If the button is pressed again during the count, the count restarts from zero. A busy flag is high while the time-out is counting. This lets the exact length of each low period be checked.

Top module: `reset_supervisor`

## Requirements
- R1: While rst_ni is low, sys_rst_no is 0 and busy_o is 0, whatever the other inputs are.
- R2: After every hold source clears (rst_ni high, pwr_good_i high, btn_ni high), sys_rst_no rises on exactly the TIMEOUT_CYC-th rising clock edge. It changes only on a rising edge of clk_i.
- R3: With pwr_good_i high, driving btn_ni to 0 (pressed) drives sys_rst_no to 0 at once, before any clock edge.
- R4: sys_rst_no stays 0 for the whole time btn_ni is 0. The count starts only after btn_ni returns to 1, and release follows TIMEOUT_CYC rising edges later.
- R5: If btn_ni goes to 0 again during the count, the count restarts from zero. A full TIMEOUT_CYC edges are then needed after the next release.
- R6: pwr_good_i at 0 forces sys_rst_no to 0 at once. A full TIMEOUT_CYC count follows the return of pwr_good_i.
- R7: busy_o is 1 exactly when no hold source is active and the output has not yet been released. busy_o and sys_rst_no are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Active-low power-on reset, asynchronous |
| pwr_good_i | input | 1 | Supply good indication, 1 = powered |
| btn_ni | input | 1 | Push-button, 0 = pressed |
| sys_rst_no | output | 1 | Active-low system reset |
| busy_o | output | 1 | Time-out count in progress |

## Verification
A counter that restarts at the wrong moment, or misses a restart, shows up as a release one or more edges off the expected edge. The reference model catches this on the first clock after the expected release edge. A hold path that is wrongly synchronous shows sys_rst_no still high in the sample taken just after the input changes, before any edge. A release flop that fails to clear leaves busy_o and sys_rst_no out of step with the model in the first cycle after the hold source drops.

// File: rtl/rsup_pkg.sv
package rsup_pkg;
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,
    PH_COUNT = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  function automatic int cnt_width(input int cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction
endpackage

// File: rtl/rsup_req.sv
module rsup_req (
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic btn_ni,
  output logic hold_o
);
  // manual request only counts while powered; power loss holds regardless
  logic man_req;
  assign man_req = pwr_good_i & ~btn_ni;
  assign hold_o  = ~rst_ni | ~pwr_good_i | man_req;
endmodule

// File: rtl/rsup_timer.sv
module rsup_timer #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic last_o
);
  localparam int CNT_W = rsup_pkg::cnt_width(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign last_o = (cnt_q == CNT_LAST);

  // any hold source clears the count asynchronously
  always_ff @(posedge clk_i or posedge hold_i) begin
    if (hold_i)       cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (cnt_q == '0));
endmodule

// File: rtl/rsup_out.sv
module rsup_out (
  input  logic clk_i,
  input  logic hold_i,
  input  logic last_i,
  output logic rel_o
);
  // asserting low is asynchronous, releasing is synchronous
  always_ff @(posedge clk_i or posedge hold_i) begin
    if (hold_i) rel_o <= 1'b0;
    else        rel_o <= rel_o | last_i;
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic btn_ni,
  output logic sys_rst_no,
  output logic busy_o
);
  import rsup_pkg::*;

  logic   hold;
  logic   last;
  logic   rel;
  phase_e phase;

  rsup_req u_req (
    .rst_ni     (rst_ni),
    .pwr_good_i (pwr_good_i),
    .btn_ni     (btn_ni),
    .hold_o     (hold)
  );

  rsup_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .last_o (last)
  );

  rsup_out u_out (
    .clk_i  (clk_i),
    .hold_i (hold),
    .last_i (last),
    .rel_o  (rel)
  );

  always_comb begin
    if (hold)      phase = PH_HOLD;
    else if (!rel) phase = PH_COUNT;
    else           phase = PH_RUN;
  end

  assign sys_rst_no = (phase == PH_RUN);
  assign busy_o     = (phase == PH_COUNT);

  p_por_low_r1: assert property (@(posedge clk_i) !rst_ni |-> (!sys_rst_no && !busy_o));

  p_btn_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_good_i && !btn_ni) |-> !sys_rst_no);

  p_pg_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !sys_rst_no);

  p_busy_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && sys_rst_no));

  p_rise_from_count_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> $past(busy_o));
endmodule

// File: tb/reset_supervisor_test.sv
module reset_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int T = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pg = 1'b0;
  logic btn_n = 1'b1;
  logic sys_rst_n;
  logic busy;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  int  m_cnt = 0;
  bit  m_rel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_supervisor #(.TIMEOUT_CYC(T)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pwr_good_i (pg),
    .btn_ni     (btn_n),
    .sys_rst_no (sys_rst_n),
    .busy_o     (busy)
  );

  function automatic bit m_hold();
    return !rst_n || !pg || !btn_n;
  endfunction

  always @(posedge clk) begin
    if (!m_hold() && !m_rel) begin
      if (m_cnt == T-1) m_rel = 1;
      else              m_cnt++;
    end
  end

  task automatic compare(input string req);
    bit exp_o, exp_b;
    exp_o = m_rel && !m_hold();
    exp_b = !m_rel && !m_hold();
    vectors++;
    if (sys_rst_n !== exp_o || busy !== exp_b) begin
      errors++;
      $display("FAIL %s t=%0t: sys_rst_no=%b busy_o=%b expected %b %b",
               req, $time, sys_rst_n, busy, exp_o, exp_b);
    end
  endtask

  // sample after the last edge, drive new inputs, then check the async path
  task automatic step(input logic r, input logic p, input logic b, input string req);
    @(negedge clk);
    compare(req);
    rst_n = r; pg = p; btn_n = b;
    if (m_hold()) begin m_cnt = 0; m_rel = 0; end
    #1;
    compare(req);
  endtask

  task automatic check_len(input string req, input int exp_n);
    int n = 0;
    while (!sys_rst_n && n < 4*T) begin
      step(rst_n, pg, btn_n, req);
      n++;
    end
    vectors++;
    if (n != exp_n) begin
      errors++;
      $display("FAIL %s low period: got %0d edges expected %0d", req, n, exp_n);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: power-on reset, other inputs wiggled
    for (int i = 0; i < 4; i++) step(1'b0, i[0], i[1], "R1");
    step(1'b0, 1'b1, 1'b1, "R1");
    // R2: release of power-on reset, exact count
    step(1'b1, 1'b1, 1'b1, "R2");
    check_len("R2", T);
    repeat (3) step(1'b1, 1'b1, 1'b1, "R2");
    // R3/R4: manual reset, long press then release
    step(1'b1, 1'b1, 1'b0, "R3");
    repeat (2*T) step(1'b1, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 1'b1, "R4");
    check_len("R4", T);
    // R5: re-press in the middle of the count
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, "R5");
    repeat (T/2) step(1'b1, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, 0, "R5");
    step(1'b1, 1'b1, 1'b1, "R5");
    check_len("R5", T);
    // R5: re-press on the last counting cycle
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, "R5");
    repeat (T-2) step(1'b1, 1'b1, 1'b1, "R5");
    step(1'b1, 1'b1, 1'b0, "R5");
    step(1'b1, 1'b1, 1'b1, "R5");
    check_len("R5", T);
    // R6: power loss, with and without the button held
    step(1'b1, 1'b0, 1'b1, "R6");
    repeat (5) step(1'b1, 1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, 1'b1, "R6");
    check_len("R6", T);
    // R7: busy tracks count; drop power mid-count
    step(1'b1, 1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, 1'b1, "R7");
    repeat (3) step(1'b1, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, 1'b1, "R7");
    check_len("R7", T);
    repeat (4) step(1'b1, 1'b1, 1'b1, "R7");
    finish_run();
  end
endmodule